// File: doc/BRIEF.md
# Mixed-Decay PWM Chopper Controller

This block drives one motor winding at constant current. A free-running counter divides time into chopping periods of a fixed number of system clocks. Each period opens with a forced charge interval, the blanking time. During blanking the current comparator is ignored. After blanking, a synchronized comparator input tells the block whether the coil current has reached the set current. The block then chooses the bridge drive state for every remaining clock of the period: charge, slow decay or fast decay.

A 2-bit decay selector picks one of three modes. In slow mode the current recirculates after it reaches the set point. In fast mode the current is actively driven down instead. Mixed mode decides by what the comparator reports just after blanking. If the current is still below the set point, the block charges up to it, then recirculates, and then applies a short fast-decay tail at the end of the period. If the current is already above the set point, the block uses fast decay for the rest of the period.

The outputs are a 2-bit bridge code for the downstream gate logic and a one-cycle strobe at each period start. Dead time, sensing and conversion are handled outside the block.

Top module: `chop_ctrl`

## Requirements
- R1: `period_start` is high for exactly one cycle every PERIOD_CLKS cycles. It is high in the first cycle after reset, and the counter keeps running while `en` is low.
- R2: Bridge codes are 2'b00 OFF (all switches open), 2'b01 CHARGE, 2'b10 SLOW and 2'b11 FAST. While `en` is low, `bridge` is OFF.
- R3: With `en` high, the first BLANK_CLKS cycles of every period are CHARGE, whatever the comparator reports.
- R4: `cmp_raw` passes through two flip-flops. A level driven before clock edge n first affects `bridge` after edge n+1.
- R5: Slow mode (`decay_sel` 2'b00): after blanking, the bridge stays CHARGE until the synchronized comparator is high. It is then SLOW until the period ends.
- R6: Fast mode (`decay_sel` 2'b10): the sequence is the same as in slow mode, with FAST in place of SLOW.
- R7: Mixed mode (`decay_sel` 2'b01, or 2'b11 which is treated the same): if the synchronized comparator is high in the first cycle after blanking, the bridge is FAST for the rest of the period.
- R8: Mixed mode, when the comparator is low in that first cycle: the bridge is CHARGE until the comparator goes high, then SLOW. The last TAIL_CLKS cycles of the period are always FAST.
- R9: `decay_sel` is sampled in the last cycle of a period and governs the whole of the next period. A change in the middle of a period has no effect on that period. After reset the mode is mixed.
- R10: Once a period has left CHARGE after blanking, it does not return to CHARGE before the period ends, even if the comparator falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Drive enable; low forces OFF |
| decay_sel | input | 2 | Decay mode: 00 slow, 01 mixed, 10 fast, 11 mixed |
| cmp_raw | input | 1 | Asynchronous comparator: coil current at or above the set current |
| bridge | output | 2 | Bridge drive code (00 OFF, 01 CHARGE, 10 SLOW, 11 FAST) |
| period_start | output | 1 | High in the first cycle of each chopping period |

## Verification
The embedded properties check on every cycle that:
- enable low gives OFF;
- blanking is always CHARGE;
- the strobe never lasts two cycles;
- slow and fast modes never use each other's decay state;
- the mixed-mode tail is FAST;
- a SLOW state within a period is followed only by decay states.

Other behaviours depend on sequences that only the bench scenarios can show:
- the two-cycle comparator latency;
- the early-crossing choice between fast-only and slow-then-fast;
- the period-boundary sampling of the mode selector.

The bench runs a behavioural coil model against a random set current, so both the rising-current and falling-current cases occur, and it changes the mode in the middle of periods.

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int PERIOD_CLKS = 600,
  parameter int BLANK_CLKS  = 50,
  parameter int TAIL_CLKS   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] decay_sel,
  input  logic       cmp_raw,
  output logic [1:0] bridge,
  output logic       period_start
);
  localparam int CW = $clog2(PERIOD_CLKS);
  localparam logic [CW-1:0] LAST       = CW'(PERIOD_CLKS - 1);
  localparam logic [CW-1:0] BLANK_END  = CW'(BLANK_CLKS);
  localparam logic [CW-1:0] TAIL_START = CW'(PERIOD_CLKS - TAIL_CLKS);
  localparam logic [1:0] BR_OFF = 2'b00, BR_CHG = 2'b01, BR_SLOW = 2'b10, BR_FAST = 2'b11;
  localparam logic [1:0] M_SLOW = 2'b00, M_MIX = 2'b01, M_FAST = 2'b10;

  logic [CW-1:0] cnt_q;
  logic          cmp_m, cmp_s;
  logic          over_q, early_q;
  logic [1:0]    mode_q;
  logic [1:0]    phase;

  wire wrap     = (cnt_q == LAST);
  wire in_blank = (cnt_q < BLANK_END);
  wire in_tail  = (cnt_q >= TAIL_START);
  wire over     = over_q | (cmp_s & ~in_blank);
  wire early    = early_q | (cmp_s & (cnt_q == BLANK_END));
  wire [1:0] sel_dec = (decay_sel == 2'b11) ? M_MIX : decay_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cmp_m   <= 1'b0;
      cmp_s   <= 1'b0;
      over_q  <= 1'b0;
      early_q <= 1'b0;
      mode_q  <= M_MIX;
    end else begin
      cmp_m <= cmp_raw;
      cmp_s <= cmp_m;
      if (wrap) begin
        cnt_q   <= '0;
        over_q  <= 1'b0;
        early_q <= 1'b0;
        mode_q  <= sel_dec;
      end else begin
        cnt_q   <= cnt_q + CW'(1);
        over_q  <= over;
        early_q <= early;
      end
    end
  end

  always_comb begin
    if (in_blank) phase = BR_CHG;
    else begin
      case (mode_q)
        M_SLOW:  phase = over ? BR_SLOW : BR_CHG;
        M_FAST:  phase = over ? BR_FAST : BR_CHG;
        default: phase = (in_tail || early) ? BR_FAST : (over ? BR_SLOW : BR_CHG);
      endcase
    end
  end

  assign bridge       = en ? phase : BR_OFF;
  assign period_start = (cnt_q == '0);

  p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> bridge == BR_OFF);
  p_blank_charge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q < BLANK_END) |-> bridge == BR_CHG);
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);
  p_slow_no_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLOW) |-> bridge != BR_FAST);
  p_fast_no_slow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FAST) |-> bridge != BR_SLOW);
  p_mixed_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode_q == M_MIX && cnt_q >= TAIL_START) |-> bridge == BR_FAST);
  p_decay_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bridge == BR_SLOW && !wrap) |=> (!en || bridge == BR_SLOW || bridge == BR_FAST));
endmodule

// File: tb/chop_ctrl_tb.sv
module chop_ctrl_tb;
  localparam int P = 40, B = 5, T = 4;
  localparam int NCYC = 6000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cmp_raw = 1'b0;
  logic [1:0] decay_sel = 2'b01;
  logic [1:0] bridge;
  logic period_start;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  chop_ctrl #(.PERIOD_CLKS(P), .BLANK_CLKS(B), .TAIL_CLKS(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .decay_sel(decay_sel),
    .cmp_raw(cmp_raw), .bridge(bridge), .period_start(period_start));

  function automatic logic [1:0] dec_mode(input logic [1:0] s);
    return (s == 2'b11) ? 2'b01 : s;
  endfunction

  function automatic logic [1:0] exp_br(input int ks, input logic [1:0] m,
      input logic ov, input logic ea, input logic cs, input logic e);
    logic o, f;
    o = ov | (cs & (ks >= B));
    f = ea | (cs & (ks == B));
    if (!e) return 2'b00;
    if (ks < B) return 2'b01;
    case (m)
      2'b00: return o ? 2'b10 : 2'b01;
      2'b10: return o ? 2'b11 : 2'b01;
      default: return (ks >= P - T || f) ? 2'b11 : (o ? 2'b10 : 2'b01);
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k, coil, setp, ks, gain;
    logic [1:0] emode, ex;
    logic ov, ea, d1, d2, cs, midchg;
    string tag;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R2 reset off", bridge, 0);
    en = 1'b1;
    #1 check("R1 reset strobe", period_start, 1);
    check("R3 reset charge", bridge, 1);
    rst_n = 1'b1;
    k = 0; coil = 0; setp = 40; emode = 2'b01;
    ov = 0; ea = 0; d1 = 0; d2 = 0; midchg = 0;
    for (int n = 0; n < NCYC; n++) begin
      ks = k % P;
      cs = d2;
      check("R1 strobe", period_start, (ks == 0) ? 1 : 0);
      ex = exp_br(ks, emode, ov, ea, cs, en);
      if (!en) tag = "R2";
      else if (ks < B) tag = "R3";
      else if (emode == 2'b00) tag = "R5";
      else if (emode == 2'b10) tag = "R6";
      else if (ea || (cs && ks == B)) tag = "R7";
      else tag = "R8";
      if (midchg) tag = {tag, " R9"};
      if (ov && !cs) tag = {tag, " R10"};
      if (cs != d1) tag = {tag, " R4"};
      check(tag, bridge, ex);
      if (ks == P - 1) begin ov = 0; ea = 0; end
      else begin
        if (cs && ks >= B) ov = 1;
        if (cs && ks == B) ea = 1;
      end
      case (ex)
        2'b01: coil += 3;
        2'b10: coil -= 1;
        2'b11: coil -= 4;
        default: coil -= 2;
      endcase
      if (coil < 0) coil = 0;
      if (ks == P - 1) begin
        setp = 5 + int'($urandom_range(0, 95));
        gain = int'($urandom_range(0, 3));
        decay_sel = 2'(gain);
        midchg = 0;
      end else if (ks == P / 2 && $urandom_range(0, 2) == 0) begin
        decay_sel = 2'($urandom_range(0, 3));
        midchg = 1;
      end
      if (n > 4000 && n < 4600) en = ($urandom_range(0, 3) != 0);
      else en = 1'b1;
      cmp_raw = (coil >= setp);
      if ((n % 97) == 50) cmp_raw = ~cmp_raw;
      d2 = d1; d1 = cmp_raw;
      if (ks == P - 1) emode = dec_mode(decay_sel);
      k++;
      @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule